// File: doc/BRIEF.md
# Sixteen-Bit Lookahead Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit. It is built from four 4-bit slices and one carry lookahead stage. A single 3-bit function code goes to all four slices and picks one of eight operations:

- clear,
- reverse subtract,
- forward subtract,
- add,
- bitwise XOR, OR and AND,
- set-all-ones.

Each of the three lower slices condenses its nibble into an active-low group propagate and generate pair. The lookahead stage turns those three pairs and the word carry input into the carry inputs of slices 1, 2 and 3 at once. The most significant slice ripples its carry internally, so it can report the carry leaving bit 15 and the carry entering bit 15. From these two carries it forms the carry-out and the signed overflow flag.

A subtraction is performed as the sum of one operand and the complement of the other. The carry input must therefore be 1 to obtain a true difference. With the carry input at 0, the result is the difference minus one, which is the building step of a multi-word borrow chain.

Top module: `alu16_cla`

## Requirements
- R1: With func_sel = 3'd0 (clear), result is 16'h0000 for any operands and carry_in.
- R2: With func_sel = 3'd7 (set), result is 16'hFFFF for any operands and carry_in.
- R3: With func_sel = 3'd3 (add), {carry_out, result} equals op_a + op_b + carry_in as a 17-bit sum.
- R4: With func_sel = 3'd2 (forward subtract), {carry_out, result} equals op_a + ~op_b + carry_in as a 17-bit sum, so carry_in = 1 gives op_a - op_b and carry_out = 1 means no borrow.
- R5: With func_sel = 3'd1 (reverse subtract), {carry_out, result} equals op_b + ~op_a + carry_in as a 17-bit sum.
- R6: With func_sel = 3'd4, 3'd5 and 3'd6, result is op_a ^ op_b, op_a | op_b and op_a & op_b respectively, and carry_in has no effect on result.
- R7: In the three arithmetic codes, ovf is 1 exactly when the two addends of R3 to R5 have equal bit 15 and result bit 15 differs from it, which is the same as the carry into bit 15 differing from the carry out of bit 15.
- R8: In the five non-arithmetic codes (0, 4, 5, 6, 7), carry_out and ovf are both 0.
- R9: A carry generated in any nibble reaches every higher nibble through the lookahead stage, so 16'hFFFF + 0 with carry_in = 1 yields result 16'h0000 and carry_out = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 (active high) |
| func_sel | input | 3 | Operation code shared by all slices |
| result | output | 16 | Function output |
| carry_out | output | 1 | Carry out of bit 15, arithmetic codes only |
| ovf | output | 1 | Signed overflow, arithmetic codes only |

## Verification
The bound checker evaluates every input change. It confirms the constant outputs of clear and set, the exact 17-bit sum of the add code, and the AND code. It also confirms that carry-out and overflow stay quiet outside arithmetic, and that overflow matches the sign rule in all three arithmetic codes.

The bench's scenarios are needed for the rest: the exact values of both subtract directions, and carry_in having no effect in the logic codes. They also cover carries that must cross every nibble boundary through the lookahead stage, and the signed corner operands 16'h7FFF and 16'h8000. Those values are compared against a reference model in the bench.

// File: rtl/alu16_cla.sv
module alu16_cla (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  input  logic [2:0]  func_sel,
  output logic [15:0] result,
  output logic        carry_out,
  output logic        ovf
);
  localparam int NIB    = 4;
  localparam int SLICES = 4;
  localparam int LOWER  = SLICES - 1;

  localparam logic [2:0] FN_CLEAR = 3'd0;
  localparam logic [2:0] FN_BSUBA = 3'd1;
  localparam logic [2:0] FN_ASUBB = 3'd2;
  localparam logic [2:0] FN_ADD   = 3'd3;
  localparam logic [2:0] FN_XOR   = 3'd4;
  localparam logic [2:0] FN_OR    = 3'd5;
  localparam logic [2:0] FN_AND   = 3'd6;
  localparam logic [2:0] FN_SET   = 3'd7;

  logic              arith;
  logic [15:0]       xo, yo;
  logic [LOWER-1:0]  grp_p_n, grp_g_n;
  logic [LOWER-1:0]  grp_p, grp_g;
  logic [SLICES-1:0] nib_cin;

  assign arith = (func_sel == FN_BSUBA) || (func_sel == FN_ASUBB) || (func_sel == FN_ADD);
  assign xo    = (func_sel == FN_BSUBA) ? ~op_a : op_a;
  assign yo    = (func_sel == FN_ASUBB) ? ~op_b : op_b;

  function automatic logic [NIB-1:0] pick(input logic [2:0] fs, input logic [NIB-1:0] a,
                                          input logic [NIB-1:0] b, input logic [NIB-1:0] s);
    case (fs)
      FN_CLEAR: pick = '0;
      FN_XOR:   pick = a ^ b;
      FN_OR:    pick = a | b;
      FN_AND:   pick = a & b;
      FN_SET:   pick = '1;
      default:  pick = s;
    endcase
  endfunction

  assign grp_p = ~grp_p_n;
  assign grp_g = ~grp_g_n;

  assign nib_cin[0] = carry_in;
  assign nib_cin[1] = grp_g[0] | (grp_p[0] & carry_in);
  assign nib_cin[2] = grp_g[1] | (grp_p[1] & grp_g[0]) | (grp_p[1] & grp_p[0] & carry_in);
  assign nib_cin[3] = grp_g[2] | (grp_p[2] & grp_g[1]) | (grp_p[2] & grp_p[1] & grp_g[0])
                    | (grp_p[2] & grp_p[1] & grp_p[0] & carry_in);

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic [NIB-1:0] px, gx, sx;
    logic [NIB:0]   cr;

    assign px    = xo[k*NIB +: NIB] | yo[k*NIB +: NIB];
    assign gx    = xo[k*NIB +: NIB] & yo[k*NIB +: NIB];
    assign cr[0] = nib_cin[k];
    for (genvar i = 0; i < NIB; i++) begin : g_bit
      assign cr[i+1] = gx[i] | (px[i] & cr[i]);
      assign sx[i]   = xo[k*NIB+i] ^ yo[k*NIB+i] ^ cr[i];
    end

    assign result[k*NIB +: NIB] = pick(func_sel, op_a[k*NIB +: NIB], op_b[k*NIB +: NIB], sx);

    if (k < LOWER) begin : g_look
      logic gg;
      assign gg         = gx[3] | (px[3] & gx[2]) | (px[3] & px[2] & gx[1])
                        | (px[3] & px[2] & px[1] & gx[0]);
      assign grp_g_n[k] = ~(arith & gg);
      assign grp_p_n[k] = ~(arith & (&px));
    end else begin : g_ripple
      assign carry_out = arith & cr[NIB];
      assign ovf       = arith & (cr[NIB] ^ cr[NIB-1]);
    end
  end
endmodule

module alu16_cla_chk (
  input logic [15:0] op_a,
  input logic [15:0] op_b,
  input logic        carry_in,
  input logic [2:0]  func_sel,
  input logic [15:0] result,
  input logic        carry_out,
  input logic        ovf
);
  logic [16:0] add_ref;
  assign add_ref = {1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in};

  always_comb begin
    assert_clear_zero_R1: assert (func_sel != 3'd0 || result == 16'h0000)
      else $error("clear code gave %h", result);
    assert_set_ones_R2: assert (func_sel != 3'd7 || result == 16'hFFFF)
      else $error("set code gave %h", result);
    assert_add_sum_R3: assert (func_sel != 3'd3 || {carry_out, result} == add_ref)
      else $error("add mismatch %h", {carry_out, result});
    assert_and_bits_R6: assert (func_sel != 3'd6 || result == (op_a & op_b))
      else $error("and mismatch %h", result);
    assert_flags_quiet_R8: assert (func_sel == 3'd1 || func_sel == 3'd2 || func_sel == 3'd3
                                   || (carry_out == 1'b0 && ovf == 1'b0))
      else $error("flags active outside arithmetic");
    assert_ovf_add_R7: assert (func_sel != 3'd3
                               || ovf == (op_a[15] == op_b[15] && result[15] != op_a[15]))
      else $error("add overflow wrong");
    assert_ovf_asubb_R7: assert (func_sel != 3'd2
                                 || ovf == (op_a[15] != op_b[15] && result[15] != op_a[15]))
      else $error("a-b overflow wrong");
    assert_ovf_bsuba_R7: assert (func_sel != 3'd1
                                 || ovf == (op_a[15] != op_b[15] && result[15] != op_b[15]))
      else $error("b-a overflow wrong");
  end
endmodule

bind alu16_cla alu16_cla_chk u_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .func_sel(func_sel),
  .result(result), .carry_out(carry_out), .ovf(ovf)
);

// File: tb/alu16_cla_tb.sv
module alu16_cla_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        ci = 1'b0;
  logic [2:0]  fs = 3'd0;
  logic [15:0] f;
  logic        co, ov;
  int          n_run = 0, n_fail = 0, cycles = 0;
  bit          done = 1'b0;

  alu16_cla u_dut (.op_a(a), .op_b(b), .carry_in(ci), .func_sel(fs),
                   .result(f), .carry_out(co), .ovf(ov));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [17:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic c, input logic [2:0] s);
    logic [15:0] p, q, r;
    logic [16:0] t;
    case (s)
      3'd1, 3'd2, 3'd3: begin
        p = (s == 3'd1) ? y : x;
        q = (s == 3'd1) ? ~x : (s == 3'd2) ? ~y : y;
        t = {1'b0, p} + {1'b0, q} + {16'd0, c};
        r = t[15:0];
        model = {(p[15] == q[15]) && (r[15] != p[15]), t[16], r};
      end
      3'd4: model = {2'b00, x ^ y};
      3'd5: model = {2'b00, x | y};
      3'd6: model = {2'b00, x & y};
      3'd7: model = {2'b00, 16'hFFFF};
      default: model = 18'd0;
    endcase
  endfunction

  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c,
                       input logic [2:0] s);
    @(negedge clk);
    a = x; b = y; ci = c; fs = s;
    #1;
  endtask

  task automatic vec(input string tag, input logic [15:0] x, input logic [15:0] y,
                     input logic c, input logic [2:0] s);
    logic [17:0] exp;
    apply(x, y, c, s);
    exp = model(x, y, c, s);
    n_run++;
    if ({ov, co, f} !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d a=%h b=%h ci=%0b: actual ovf=%0b cout=%0b f=%h expected ovf=%0b cout=%0b f=%h",
               tag, s, x, y, c, ov, co, f, exp[17], exp[16], exp[15:0]);
    end
  endtask

  task automatic t_initial;
    #1;
    n_run++;
    if (f !== 16'h0000 || co !== 1'b0 || ov !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 initial: actual f=%h cout=%0b ovf=%0b expected 0000/0/0", f, co, ov);
    end
  endtask

  task automatic t_constants;
    vec("R1", 16'hFFFF, 16'hFFFF, 1'b1, 3'd0);
    vec("R1", 16'h1234, 16'h8000, 1'b0, 3'd0);
    vec("R2", 16'h0000, 16'h0000, 1'b0, 3'd7);
    vec("R2", 16'hFFFF, 16'h7FFF, 1'b1, 3'd7);
    vec("R8", 16'hFFFF, 16'hFFFF, 1'b1, 3'd7);
  endtask

  task automatic t_add;
    vec("R3", 16'h1234, 16'h4321, 1'b0, 3'd3);
    vec("R3", 16'h00FF, 16'h0001, 1'b1, 3'd3);
    vec("R3", 16'hFFFF, 16'hFFFF, 1'b1, 3'd3);
    vec("R7", 16'h7FFF, 16'h0001, 1'b0, 3'd3);
    vec("R7", 16'h8000, 16'h8000, 1'b0, 3'd3);
    vec("R7", 16'h7FFF, 16'h0000, 1'b1, 3'd3);
  endtask

  task automatic t_sub;
    vec("R4", 16'h5000, 16'h1234, 1'b1, 3'd2);
    vec("R4", 16'h0000, 16'h0001, 1'b1, 3'd2);
    vec("R4", 16'h0005, 16'h0005, 1'b0, 3'd2);
    vec("R7", 16'h8000, 16'h0001, 1'b1, 3'd2);
    vec("R5", 16'h1234, 16'h5000, 1'b1, 3'd1);
    vec("R5", 16'h0001, 16'h0000, 1'b1, 3'd1);
    vec("R5", 16'hFFFF, 16'h0000, 1'b0, 3'd1);
    vec("R7", 16'h0001, 16'h8000, 1'b1, 3'd1);
  endtask

  task automatic t_logic;
    for (int s = 4; s <= 6; s++) begin
      vec("R6", 16'hF0F0, 16'hFF00, 1'b0, 3'(s));
      vec("R6", 16'hF0F0, 16'hFF00, 1'b1, 3'(s));
      vec("R8", 16'hFFFF, 16'hFFFF, 1'b1, 3'(s));
    end
  endtask

  task automatic t_chain;
    vec("R9", 16'hFFFF, 16'h0000, 1'b1, 3'd3);
    vec("R9", 16'h0FFF, 16'h0001, 1'b0, 3'd3);
    vec("R9", 16'h00FF, 16'h0F01, 1'b0, 3'd3);
    vec("R9", 16'h000F, 16'h0FF1, 1'b0, 3'd3);
    vec("R9", 16'h0000, 16'h0000, 1'b1, 3'd2);
  endtask

  task automatic t_random;
    logic [15:0] corners [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++)
            vec("R3/R4/R5/R6/R7 corner", corners[i], corners[j], 1'(c), 3'(s));
    for (int k = 0; k < 800; k++)
      vec("R3/R4/R5/R6/R7 random", 16'($urandom), 16'($urandom), 1'($urandom), 3'($urandom));
  endtask

  initial begin
    t_initial;
    t_constants;
    t_add;
    t_sub;
    t_logic;
    t_chain;
    t_random;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule